// File: doc/BRIEF.md
# Single-Cycle Instruction Control Decoder

This block turns the opcode and function field of the current instruction into the full set of datapath controls for a small 32-bit processor in which each instruction completes in one clock cycle. It has no clock and holds no state. The register file, ALU, memories and next-PC logic sit around it and consume its outputs in the same cycle that the instruction word is presented.

The decoder covers register-format arithmetic (add, subtract, and, or), set-on-less-than and register jump, which it tells apart by the function field. It also covers load word, store word, add-immediate, or-immediate, load-upper-immediate, branch-if-equal, jump and jump-and-link, which it tells apart by the opcode. Each instruction gets its own immediate treatment: sign extension, zero extension, or placement in the upper half of the word. Any opcode or function code outside this set yields a quiet control word that writes nothing and lets the PC advance.

Top module: `cpu_ctl_decoder`

## Requirements
- R1: The outputs are a pure function of `opcode_i` and `funct_i` and do not depend on earlier inputs. Field codes: alu_op 0 add, 1 subtract, 2 and, 3 or, 4 set-less-than, 5 pass operand B. dst_sel 0 rt, 1 rd, 2 register 31. wb_sel 0 ALU result, 1 memory data, 2 PC+1. ext_mode 0 sign, 1 zero, 2 upper half. pc_mode 0 sequential, 1 branch-if-equal, 2 jump target, 3 register value.
- R2: With opcode 0x00 and funct 0x20/0x22/0x24/0x25, alu_op is 0/1/2/3, operand B is the register (alu_src_imm 0), reg_we is 1, dst_sel is rd, wb_sel is ALU, pc_mode is sequential and mem_we is 0.
- R3: With opcode 0x00 and funct 0x2A, alu_op is set-less-than and the result is written to rd from the ALU, with operand B from the register.
- R4: With opcode 0x00 and funct 0x08, pc_mode is register and no register or memory write occurs.
- R5: Opcode 0x23 (load) selects add, immediate operand, sign extension, writes rt from memory data, and does not write memory.
- R6: Opcode 0x2B (store) selects add, immediate operand, sign extension, asserts mem_we and writes no register. mem_we is asserted for no other opcode.
- R7: Opcode 0x08 (add-immediate) selects add, immediate operand, sign extension and writes rt from the ALU.
- R8: Opcode 0x0D (or-immediate) selects or, immediate operand, zero extension and writes rt from the ALU.
- R9: Opcode 0x0F (load-upper) selects pass-B, immediate operand, upper-half placement and writes rt from the ALU.
- R10: Opcode 0x04 (branch-if-equal) selects subtract with the register operand, sign extension and pc_mode branch, and writes nothing.
- R11: Opcode 0x02 (jump) gives pc_mode jump target and writes nothing. Opcode 0x03 (jump-and-link) gives pc_mode jump target, reg_we 1, dst_sel register 31 and wb_sel PC+1.
- R12: Any other opcode, or opcode 0x00 with any other funct, gives an all-zero control word (no writes, sequential PC). The funct field has no effect when the opcode is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opcode_i | input | 6 | Instruction bits 31:26 |
| funct_i | input | 6 | Instruction bits 5:0 |
| alu_op_o | output | 3 | ALU operation code |
| alu_src_imm_o | output | 1 | 1: ALU operand B is the extended immediate |
| reg_we_o | output | 1 | Register file write enable |
| dst_sel_o | output | 2 | Destination register choice |
| mem_we_o | output | 1 | Data memory write enable |
| wb_sel_o | output | 2 | Write-back data source |
| ext_mode_o | output | 2 | Immediate extension mode |
| pc_mode_o | output | 2 | Next-PC mode |

## Verification
The block holds no state, so an internal fault can only be a wrong mapping. Such a fault shows on the output ports in the same evaluation as the offending instruction, with no delay in cycles. The most harmful faults are a write enable raised for a branch, a jump or an unknown code, which would corrupt a register or memory word, and a wrong extension mode, which would shift an address or a constant. The bench sweeps every opcode and function pairing to catch any stray enable, and it checks each supported instruction field by field.

// File: rtl/ctl_dec_pkg.sv
package ctl_dec_pkg;

    localparam int OP_W = 6;
    localparam int FN_W = 6;

    localparam logic [OP_W-1:0] OPC_REG   = 6'h00;
    localparam logic [OP_W-1:0] OPC_JMP   = 6'h02;
    localparam logic [OP_W-1:0] OPC_JLINK = 6'h03;
    localparam logic [OP_W-1:0] OPC_BEQ   = 6'h04;
    localparam logic [OP_W-1:0] OPC_ADDI  = 6'h08;
    localparam logic [OP_W-1:0] OPC_ORI   = 6'h0D;
    localparam logic [OP_W-1:0] OPC_LUI   = 6'h0F;
    localparam logic [OP_W-1:0] OPC_LOAD  = 6'h23;
    localparam logic [OP_W-1:0] OPC_STORE = 6'h2B;

    localparam logic [FN_W-1:0] FN_JREG = 6'h08;
    localparam logic [FN_W-1:0] FN_ADD  = 6'h20;
    localparam logic [FN_W-1:0] FN_SUB  = 6'h22;
    localparam logic [FN_W-1:0] FN_AND  = 6'h24;
    localparam logic [FN_W-1:0] FN_OR   = 6'h25;
    localparam logic [FN_W-1:0] FN_SLT  = 6'h2A;

    typedef enum logic [2:0] {
        ALU_ADD   = 3'd0,
        ALU_SUB   = 3'd1,
        ALU_AND   = 3'd2,
        ALU_OR    = 3'd3,
        ALU_SLT   = 3'd4,
        ALU_PASSB = 3'd5
    } alu_op_e;

    typedef enum logic [1:0] {
        DST_RT   = 2'd0,
        DST_RD   = 2'd1,
        DST_LINK = 2'd2
    } dst_e;

    typedef enum logic [1:0] {
        WB_ALU  = 2'd0,
        WB_MEM  = 2'd1,
        WB_LINK = 2'd2
    } wb_e;

    typedef enum logic [1:0] {
        EXT_SIGN  = 2'd0,
        EXT_ZERO  = 2'd1,
        EXT_UPPER = 2'd2
    } ext_e;

    typedef enum logic [1:0] {
        PC_SEQ  = 2'd0,
        PC_BEQ  = 2'd1,
        PC_JUMP = 2'd2,
        PC_REG  = 2'd3
    } pc_e;

    typedef enum logic [3:0] {
        MJ_NOP,
        MJ_REG,
        MJ_LOAD,
        MJ_STORE,
        MJ_ADDI,
        MJ_ORI,
        MJ_LUI,
        MJ_BEQ,
        MJ_JMP,
        MJ_JLINK
    } major_e;

    typedef enum logic [2:0] {
        RK_BAD,
        RK_ADD,
        RK_SUB,
        RK_AND,
        RK_OR,
        RK_SLT,
        RK_JREG
    } rkind_e;

    typedef struct packed {
        alu_op_e alu_op;
        logic    src_imm;
        logic    reg_we;
        dst_e    dst;
        logic    mem_we;
        wb_e     wb;
        ext_e    ext;
        pc_e     pc;
    } ctl_word_t;

    localparam int CTL_W = $bits(ctl_word_t);

    localparam ctl_word_t CTL_QUIET = '{
        alu_op:  ALU_ADD,
        src_imm: 1'b0,
        reg_we:  1'b0,
        dst:     DST_RT,
        mem_we:  1'b0,
        wb:      WB_ALU,
        ext:     EXT_SIGN,
        pc:      PC_SEQ
    };

endpackage

// File: rtl/ctl_dec_major.sv
module ctl_dec_major
    import ctl_dec_pkg::*;
(
    input  logic [OP_W-1:0] opcode_i,
    output major_e          major_o
);
    major_e major_d;

    always_comb begin
        case (opcode_i)
            OPC_REG:   major_d = MJ_REG;
            OPC_LOAD:  major_d = MJ_LOAD;
            OPC_STORE: major_d = MJ_STORE;
            OPC_ADDI:  major_d = MJ_ADDI;
            OPC_ORI:   major_d = MJ_ORI;
            OPC_LUI:   major_d = MJ_LUI;
            OPC_BEQ:   major_d = MJ_BEQ;
            OPC_JMP:   major_d = MJ_JMP;
            OPC_JLINK: major_d = MJ_JLINK;
            default:   major_d = MJ_NOP;
        endcase
    end

    assign major_o = major_d;
endmodule

// File: rtl/ctl_dec_func.sv
module ctl_dec_func
    import ctl_dec_pkg::*;
(
    input  logic [FN_W-1:0] funct_i,
    output rkind_e          rkind_o
);
    rkind_e rkind_d;

    always_comb begin
        case (funct_i)
            FN_ADD:  rkind_d = RK_ADD;
            FN_SUB:  rkind_d = RK_SUB;
            FN_AND:  rkind_d = RK_AND;
            FN_OR:   rkind_d = RK_OR;
            FN_SLT:  rkind_d = RK_SLT;
            FN_JREG: rkind_d = RK_JREG;
            default: rkind_d = RK_BAD;
        endcase
    end

    assign rkind_o = rkind_d;
endmodule

// File: rtl/ctl_dec_assemble.sv
module ctl_dec_assemble
    import ctl_dec_pkg::*;
(
    input  major_e    major_i,
    input  rkind_e    rkind_i,
    output ctl_word_t ctl_o
);
    ctl_word_t ctl_d;

    always_comb begin
        ctl_d = CTL_QUIET;
        case (major_i)
            MJ_REG: begin
                ctl_d.dst = DST_RD;
                case (rkind_i)
                    RK_ADD: begin ctl_d.reg_we = 1'b1; ctl_d.alu_op = ALU_ADD; end
                    RK_SUB: begin ctl_d.reg_we = 1'b1; ctl_d.alu_op = ALU_SUB; end
                    RK_AND: begin ctl_d.reg_we = 1'b1; ctl_d.alu_op = ALU_AND; end
                    RK_OR:  begin ctl_d.reg_we = 1'b1; ctl_d.alu_op = ALU_OR;  end
                    RK_SLT: begin ctl_d.reg_we = 1'b1; ctl_d.alu_op = ALU_SLT; end
                    RK_JREG: begin
                        ctl_d.dst = DST_RT;
                        ctl_d.pc  = PC_REG;
                    end
                    default: ctl_d = CTL_QUIET;
                endcase
            end
            MJ_LOAD: begin
                ctl_d.src_imm = 1'b1;
                ctl_d.reg_we  = 1'b1;
                ctl_d.wb      = WB_MEM;
            end
            MJ_STORE: begin
                ctl_d.src_imm = 1'b1;
                ctl_d.mem_we  = 1'b1;
            end
            MJ_ADDI: begin
                ctl_d.src_imm = 1'b1;
                ctl_d.reg_we  = 1'b1;
            end
            MJ_ORI: begin
                ctl_d.src_imm = 1'b1;
                ctl_d.reg_we  = 1'b1;
                ctl_d.alu_op  = ALU_OR;
                ctl_d.ext     = EXT_ZERO;
            end
            MJ_LUI: begin
                ctl_d.src_imm = 1'b1;
                ctl_d.reg_we  = 1'b1;
                ctl_d.alu_op  = ALU_PASSB;
                ctl_d.ext     = EXT_UPPER;
            end
            MJ_BEQ: begin
                ctl_d.alu_op = ALU_SUB;
                ctl_d.pc     = PC_BEQ;
            end
            MJ_JMP: begin
                ctl_d.pc = PC_JUMP;
            end
            MJ_JLINK: begin
                ctl_d.pc     = PC_JUMP;
                ctl_d.reg_we = 1'b1;
                ctl_d.dst    = DST_LINK;
                ctl_d.wb     = WB_LINK;
            end
            default: ctl_d = CTL_QUIET;
        endcase
    end

    assign ctl_o = ctl_d;
endmodule

// File: rtl/cpu_ctl_decoder.sv
module cpu_ctl_decoder
    import ctl_dec_pkg::*;
(
    input  logic [5:0] opcode_i,
    input  logic [5:0] funct_i,
    output logic [2:0] alu_op_o,
    output logic       alu_src_imm_o,
    output logic       reg_we_o,
    output logic [1:0] dst_sel_o,
    output logic       mem_we_o,
    output logic [1:0] wb_sel_o,
    output logic [1:0] ext_mode_o,
    output logic [1:0] pc_mode_o
);
    major_e    major;
    rkind_e    rkind;
    ctl_word_t ctl;

    ctl_dec_major u_major (
        .opcode_i (opcode_i),
        .major_o  (major)
    );

    ctl_dec_func u_func (
        .funct_i (funct_i),
        .rkind_o (rkind)
    );

    ctl_dec_assemble u_asm (
        .major_i (major),
        .rkind_i (rkind),
        .ctl_o   (ctl)
    );

    assign alu_op_o      = ctl.alu_op;
    assign alu_src_imm_o = ctl.src_imm;
    assign reg_we_o      = ctl.reg_we;
    assign dst_sel_o     = ctl.dst;
    assign mem_we_o      = ctl.mem_we;
    assign wb_sel_o      = ctl.wb;
    assign ext_mode_o    = ctl.ext;
    assign pc_mode_o     = ctl.pc;
endmodule

// File: rtl/cpu_ctl_decoder_chk.sv
module cpu_ctl_decoder_chk (
    input logic [5:0] opcode_i,
    input logic [5:0] funct_i,
    input logic [2:0] alu_op_o,
    input logic       alu_src_imm_o,
    input logic       reg_we_o,
    input logic [1:0] dst_sel_o,
    input logic       mem_we_o,
    input logic [1:0] wb_sel_o,
    input logic [1:0] ext_mode_o,
    input logic [1:0] pc_mode_o
);
    always_comb begin
        a_r6_mem_write_store_only: assert (mem_we_o == (opcode_i == 6'h2B));
        a_r6_no_dual_write: assert (!(mem_we_o && reg_we_o));
        a_r11_link_pairing: assert ((wb_sel_o == 2'd2) == (dst_sel_o == 2'd2));
        a_r9_upper_with_pass: assert ((ext_mode_o == 2'd2) == (alu_op_o == 3'd5));
        a_r4_reg_jump_source: assert (pc_mode_o != 2'd3
            || (opcode_i == 6'h00 && funct_i == 6'h08 && !reg_we_o && !mem_we_o));
        a_r10_branch_quiet: assert (pc_mode_o != 2'd1
            || (!reg_we_o && !mem_we_o && alu_op_o == 3'd1 && !alu_src_imm_o));
        a_r12_redirect_no_store: assert (pc_mode_o == 2'd0 || !mem_we_o);
    end
endmodule

bind cpu_ctl_decoder cpu_ctl_decoder_chk u_chk (.*);

// File: tb/cpu_ctl_decoder_test.sv
module cpu_ctl_decoder_test;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [5:0] opcode = 6'h00;
    logic [5:0] funct  = 6'h00;
    logic [2:0] alu_op;
    logic       alu_src_imm, reg_we, mem_we;
    logic [1:0] dst_sel, wb_sel, ext_mode, pc_mode;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    cpu_ctl_decoder uut (
        .opcode_i      (opcode),
        .funct_i       (funct),
        .alu_op_o      (alu_op),
        .alu_src_imm_o (alu_src_imm),
        .reg_we_o      (reg_we),
        .dst_sel_o     (dst_sel),
        .mem_we_o      (mem_we),
        .wb_sel_o      (wb_sel),
        .ext_mode_o    (ext_mode),
        .pc_mode_o     (pc_mode)
    );

    // vector: opcode, funct, alu_op, src_imm, reg_we, dst, mem_we, wb, ext, pc
    localparam int NV = 17;
    localparam logic [25:0] VEC [NV] = '{
        {6'h00, 6'h20, 3'd0, 1'b0, 1'b1, 2'd1, 1'b0, 2'd0, 2'd0, 2'd0},
        {6'h00, 6'h22, 3'd1, 1'b0, 1'b1, 2'd1, 1'b0, 2'd0, 2'd0, 2'd0},
        {6'h00, 6'h24, 3'd2, 1'b0, 1'b1, 2'd1, 1'b0, 2'd0, 2'd0, 2'd0},
        {6'h00, 6'h25, 3'd3, 1'b0, 1'b1, 2'd1, 1'b0, 2'd0, 2'd0, 2'd0},
        {6'h00, 6'h2A, 3'd4, 1'b0, 1'b1, 2'd1, 1'b0, 2'd0, 2'd0, 2'd0},
        {6'h00, 6'h08, 3'd0, 1'b0, 1'b0, 2'd0, 1'b0, 2'd0, 2'd0, 2'd3},
        {6'h23, 6'h00, 3'd0, 1'b1, 1'b1, 2'd0, 1'b0, 2'd1, 2'd0, 2'd0},
        {6'h2B, 6'h00, 3'd0, 1'b1, 1'b0, 2'd0, 1'b1, 2'd0, 2'd0, 2'd0},
        {6'h08, 6'h00, 3'd0, 1'b1, 1'b1, 2'd0, 1'b0, 2'd0, 2'd0, 2'd0},
        {6'h0D, 6'h00, 3'd3, 1'b1, 1'b1, 2'd0, 1'b0, 2'd0, 2'd1, 2'd0},
        {6'h0F, 6'h00, 3'd5, 1'b1, 1'b1, 2'd0, 1'b0, 2'd0, 2'd2, 2'd0},
        {6'h04, 6'h00, 3'd1, 1'b0, 1'b0, 2'd0, 1'b0, 2'd0, 2'd0, 2'd1},
        {6'h02, 6'h00, 3'd0, 1'b0, 1'b0, 2'd0, 1'b0, 2'd0, 2'd0, 2'd2},
        {6'h03, 6'h00, 3'd0, 1'b0, 1'b1, 2'd2, 1'b0, 2'd2, 2'd0, 2'd2},
        {6'h08, 6'h08, 3'd0, 1'b1, 1'b1, 2'd0, 1'b0, 2'd0, 2'd0, 2'd0},
        {6'h05, 6'h20, 3'd0, 1'b0, 1'b0, 2'd0, 1'b0, 2'd0, 2'd0, 2'd0},
        {6'h00, 6'h21, 3'd0, 1'b0, 1'b0, 2'd0, 1'b0, 2'd0, 2'd0, 2'd0}
    };

    function automatic string tag_of(input int i);
        case (i)
            0, 1, 2, 3: return "R2";
            4:          return "R3";
            5:          return "R4";
            6:          return "R5";
            7:          return "R6";
            8:          return "R7";
            9:          return "R8";
            10:         return "R9";
            11:         return "R10";
            12, 13:     return "R11";
            default:    return "R12";
        endcase
    endfunction

    function automatic bit is_supported(input logic [5:0] op, input logic [5:0] fn);
        case (op)
            6'h00: return fn inside {6'h20, 6'h22, 6'h24, 6'h25, 6'h2A, 6'h08};
            6'h23, 6'h2B, 6'h08, 6'h0D, 6'h0F, 6'h04, 6'h02, 6'h03: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [13:0] got_word();
        return {alu_op, alu_src_imm, reg_we, dst_sel, mem_we, wb_sel, ext_mode, pc_mode};
    endfunction

    task automatic drive(input logic [5:0] op, input logic [5:0] fn);
        @(posedge clk);
        #1;
        opcode = op;
        funct  = fn;
        @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [13:0] exp);
        logic [13:0] got;
        got = got_word();
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s op=%h fn=%h actual=%b expected=%b", tag, opcode, funct, got, exp);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        // reset state: inputs held at zero (opcode 0, funct 0 is unsupported) -> quiet word, R12
        repeat (2) @(negedge clk);
        check("R12 reset", 14'd0);
        rst = 1'b0;

        // table walk, forward
        for (int i = 0; i < NV; i++) begin
            drive(VEC[i][25:20], VEC[i][19:14]);
            check(tag_of(i), VEC[i][13:0]);
        end

        // R1: reverse order, so each vector follows a different predecessor
        for (int i = NV - 1; i >= 0; i--) begin
            drive(VEC[i][25:20], VEC[i][19:14]);
            check({"R1 ", tag_of(i)}, VEC[i][13:0]);
        end

        // R12: every unsupported opcode/funct pairing gives the quiet word
        for (int op = 0; op < 64; op++) begin
            for (int fn = 0; fn < 64; fn++) begin
                if (!is_supported(6'(op), 6'(fn))) begin
                    drive(6'(op), 6'(fn));
                    check("R12", 14'd0);
                end
            end
        end

        // R12 / R5: funct has no effect on a load
        for (int fn = 0; fn < 64; fn++) begin
            drive(6'h23, 6'(fn));
            check("R12 funct ignored", VEC[6][13:0]);
        end

        // R11: link after store, then jump after link
        drive(6'h2B, 6'h3F);
        check("R6", VEC[7][13:0]);
        drive(6'h03, 6'h3F);
        check("R11", VEC[13][13:0]);
        drive(6'h02, 6'h2A);
        check("R11", VEC[12][13:0]);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule